// File: doc/BRIEF.md
# Serial Control Register Port

This block receives write-only control frames over a three-wire serial link (select, clock, data) and keeps the small register file that those frames load. Every frame is sixteen bits long and is shifted in MSB first on rising serial-clock edges; it names a device, a direction and a register, and carries one data byte. The register contents are brought out as decoded control fields for power switches, the audio data format, the output filters, the soft mute, the attenuators and the output routing.

The serial pins run far slower than the system clock. They are brought into the system clock domain through synchronizer stages and the serial clock is edge-detected there. The active-low power-down input returns every register to its default value and refuses writes for as long as it is low. A frame commits only when it is complete, aimed at this device, marked as a write and addressed to an implemented register. Any other frame leaves the register file untouched.

Top module: `ctl_serial_regport`

## Requirements
- R1: After reset every output shows the default register image: register 0 = 0x00, register 1 = 0x08, register 2 = 0x01, registers 3 to 6 = 0x00.
- R2: A frame is sixteen bits sent MSB first on rising `sclk` while `cs_n` is low. Frame bits 15:14 are the device code, bit 13 is the direction flag, bits 12:8 are the register address and bits 7:0 are the data. A legal frame replaces the addressed register with the data byte.
- R3: A frame whose device code is not 2'b01 changes no register.
- R4: A frame whose direction flag is 0 changes no register.
- R5: A frame addressed to 0x07 through 0x1F changes no register.
- R6: The write takes effect on the 16th rising `sclk` edge of a frame. After 15 edges the addressed register still holds its old value.
- R7: Rising `sclk` edges after the 16th within the same selection have no effect on any register.
- R8: While `pdn_n` is low every register shows its default value and frames are discarded. Once `pdn_n` returns high the defaults remain until the next write. If power-down arrives in the same cycle as a 16th edge, no write happens.
- R9: Raising `cs_n` before the 16th edge abandons the frame, and the next selection starts again at frame bit 15.
- R10: The fields are placed as follows. Register 0: bit 4 `hp_unmute`, bit 3 `hp_pwr_r`, bit 2 `hp_pwr_l`, bit 1 `dac_pwr`, bit 0 `vref_pwr`. Register 1: bit 6 `mclk_ac`, bit 5 `mono_mix`, bits 4:2 `fmt_sel`, bits 1:0 `osr_sel`. Register 2: bit 4 `soft_mute`, bits 3:2 `boost_sel`, bits 1:0 `deemph_sel`. Register 3: bit 3 `att_slow`, bit 2 `att_link`, bit 1 `bclk_inv`, bit 0 `lr_inv`. Register 4: `att_l`. Register 5: `att_r`. Register 6: bit 1 `route_r`, bit 0 `route_l`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low system reset |
| pdn_n | input | 1 | Active-low power-down; restores defaults and blocks writes |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| sdin | input | 1 | Serial data, MSB first |
| vref_pwr | output | 1 | Reference block power enable |
| dac_pwr | output | 1 | Converter power enable |
| hp_pwr_l | output | 1 | Left headphone driver power enable |
| hp_pwr_r | output | 1 | Right headphone driver power enable |
| hp_unmute | output | 1 | Headphone driver unmute |
| osr_sel | output | 2 | Oversampling rate select |
| fmt_sel | output | 3 | Audio data format select |
| mono_mix | output | 1 | Mix left and right to both outputs |
| mclk_ac | output | 1 | Master clock AC-coupled input mode |
| deemph_sel | output | 2 | De-emphasis filter select |
| boost_sel | output | 2 | Bass boost level select |
| soft_mute | output | 1 | Soft mute request |
| lr_inv | output | 1 | Frame clock polarity invert |
| bclk_inv | output | 1 | Bit clock polarity invert |
| att_link | output | 1 | Left attenuator value drives both channels |
| att_slow | output | 1 | Slow attenuator ramp select |
| att_l | output | 8 | Left attenuator value |
| att_r | output | 8 | Right attenuator value |
| route_l | output | 1 | Left converter routed to left output |
| route_r | output | 1 | Right converter routed to right output |

## Verification
Power-down can fall in the same system-clock cycle as the 16th serial edge that would commit a legal write. The bench provokes this by lowering `pdn_n` at the same instant it raises `sclk` for the last bit. Both pins pass through synchronizers of equal depth, so the two events reach the logic together. The collision is judged a win for power-down: the targeted register must show its default both during power-down and after `pdn_n` is released, and a later legal write must still land normally.

// File: rtl/ctl_regport_pkg.sv
// Package: shared sizes, frame layout and register defaults for the
// serial control register port. Assumes one byte per register.
package ctl_regport_pkg;

    localparam int FRAME_BITS = 16;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int NREG       = 7;
    localparam logic [1:0] DEV_CODE = 2'b01;

    // Register indices, used by the field decode
    localparam int RIDX_PWR  = 0;
    localparam int RIDX_FMT  = 1;
    localparam int RIDX_FLT  = 2;
    localparam int RIDX_CLK  = 3;
    localparam int RIDX_ATTL = 4;
    localparam int RIDX_ATTR = 5;
    localparam int RIDX_RTE  = 6;

    // Decoded view of one received frame
    typedef struct packed {
        logic [1:0]        dev;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    // Power-on value of each register
    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        case (idx)
            RIDX_FMT: reg_default = 8'h08;
            RIDX_FLT: reg_default = 8'h01;
            default:  reg_default = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/ctl_bit_sync.sv
// Multi-bit synchronizer: each bit passes through STAGES flops on clk.
// Assumes the bits are slow, independent level signals. RST_VAL sets the
// value held while reset is low.
module ctl_bit_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the asynchronous pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= d_async;
                end
            end else begin : g_next
                // Later stages settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/ctl_frame_rx.sv
// Frame receiver: detects rising serial-clock edges in the system clock
// domain, shifts in data MSB first, counts edges while selected and issues
// a one-cycle write strobe for a legal frame on its final edge.
// Assumes synchronized inputs and a serial clock several times slower than clk.
module ctl_frame_rx
    import ctl_regport_pkg::*;
#(
    parameter int FBITS = FRAME_BITS,
    parameter int NR    = NREG,
    localparam int CNT_W = $clog2(FBITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pdn_s,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdin_s,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic             sclk_q;
    logic             sclk_rise;
    logic [FBITS-2:0] shreg;
    frame_t           frame_now;
    logic             frame_ok;

    // Previous serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_q;

    // Frame as it would read with the current bit appended
    assign frame_now = frame_t'({shreg, sdin_s});

    // Legality: right device, write direction, implemented register
    always_comb begin
        frame_ok = (frame_now.dev == DEV_CODE) && frame_now.wr &&
                   (frame_now.addr < ADDR_W'(NR));
    end

    // Shift, count and commit; power-down clears the frame in flight
    always_ff @(posedge clk) begin
        if (!rst_n || !pdn_s) begin
            bit_cnt <= '0;
            shreg   <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (cs_n_s) begin
                bit_cnt <= '0;
            end else if (sclk_rise && (bit_cnt < CNT_W'(FBITS))) begin
                shreg   <= {shreg[FBITS-3:0], sdin_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(FBITS - 1)) begin
                    wr_en   <= frame_ok;
                    wr_addr <= frame_now.addr;
                    wr_data <= frame_now.data;
                end
            end
        end
    end

endmodule

// File: rtl/ctl_reg_bank.sv
// Register bank: NR byte registers with per-register defaults, loaded by
// the write strobe and restored to defaults by reset or power-down.
// Assumes wr_addr is already checked to be in range when wr_en is high.
module ctl_reg_bank
    import ctl_regport_pkg::*;
#(
    parameter int NR = NREG
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pdn_s,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [NR*DATA_W-1:0] reg_flat
);

    genvar i;
    generate
        for (i = 0; i < NR; i++) begin : g_reg
            logic [DATA_W-1:0] val_q;

            // One register: default on reset or power-down, else load on hit
            always_ff @(posedge clk) begin
                if (!rst_n || !pdn_s)
                    val_q <= reg_default(i);
                else if (wr_en && (wr_addr == ADDR_W'(i)))
                    val_q <= wr_data;
            end

            assign reg_flat[i*DATA_W +: DATA_W] = val_q;
        end
    endgenerate

endmodule

// File: rtl/ctl_serial_regport.sv
// Top: three-wire write-only control port with its register file and
// decoded control fields. Assumes clk runs at least four times sclk and
// that pdn_n, cs_n, sclk and sdin are asynchronous to clk.
module ctl_serial_regport
    import ctl_regport_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdn_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       sdin,
    output logic       vref_pwr,
    output logic       dac_pwr,
    output logic       hp_pwr_l,
    output logic       hp_pwr_r,
    output logic       hp_unmute,
    output logic [1:0] osr_sel,
    output logic [2:0] fmt_sel,
    output logic       mono_mix,
    output logic       mclk_ac,
    output logic [1:0] deemph_sel,
    output logic [1:0] boost_sel,
    output logic       soft_mute,
    output logic       lr_inv,
    output logic       bclk_inv,
    output logic       att_link,
    output logic       att_slow,
    output logic [7:0] att_l,
    output logic [7:0] att_r,
    output logic       route_l,
    output logic       route_r
);

    logic                    pdn_s, cs_n_s, sclk_s, sdin_s;
    logic [CNT_W-1:0]        bit_cnt;
    logic                    wr_en;
    logic [ADDR_W-1:0]       wr_addr;
    logic [DATA_W-1:0]       wr_data;
    logic [NREG*DATA_W-1:0]  reg_flat;
    logic [DATA_W-1:0]       r_pwr, r_fmt, r_flt, r_clk, r_rte;

    ctl_bit_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({pdn_n, cs_n, sclk, sdin}),
        .q_sync  ({pdn_s, cs_n_s, sclk_s, sdin_s})
    );

    ctl_frame_rx #(
        .FBITS (FRAME_BITS),
        .NR    (NREG)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .pdn_s   (pdn_s),
        .cs_n_s  (cs_n_s),
        .sclk_s  (sclk_s),
        .sdin_s  (sdin_s),
        .bit_cnt (bit_cnt),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    ctl_reg_bank #(
        .NR (NREG)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .pdn_s    (pdn_s),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .reg_flat (reg_flat)
    );

    assign r_pwr = reg_flat[RIDX_PWR*DATA_W +: DATA_W];
    assign r_fmt = reg_flat[RIDX_FMT*DATA_W +: DATA_W];
    assign r_flt = reg_flat[RIDX_FLT*DATA_W +: DATA_W];
    assign r_clk = reg_flat[RIDX_CLK*DATA_W +: DATA_W];
    assign r_rte = reg_flat[RIDX_RTE*DATA_W +: DATA_W];

    // Field decode of the register image
    always_comb begin
        vref_pwr   = r_pwr[0];
        dac_pwr    = r_pwr[1];
        hp_pwr_l   = r_pwr[2];
        hp_pwr_r   = r_pwr[3];
        hp_unmute  = r_pwr[4];
        osr_sel    = r_fmt[1:0];
        fmt_sel    = r_fmt[4:2];
        mono_mix   = r_fmt[5];
        mclk_ac    = r_fmt[6];
        deemph_sel = r_flt[1:0];
        boost_sel  = r_flt[3:2];
        soft_mute  = r_flt[4];
        lr_inv     = r_clk[0];
        bclk_inv   = r_clk[1];
        att_link   = r_clk[2];
        att_slow   = r_clk[3];
        att_l      = reg_flat[RIDX_ATTL*DATA_W +: DATA_W];
        att_r      = reg_flat[RIDX_ATTR*DATA_W +: DATA_W];
        route_l    = r_rte[0];
        route_r    = r_rte[1];
    end

endmodule

// File: rtl/ctl_serial_regport_chk.sv
// Checker for the serial control register port, bound to the top module.
// Observes the synchronized pins, the receiver state and the register image.
module ctl_serial_regport_chk
    import ctl_regport_pkg::*;
#(
    localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pdn_s,
    input logic                   cs_n_s,
    input logic [CNT_W-1:0]       bit_cnt,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      wr_addr,
    input logic [NREG*DATA_W-1:0] reg_flat,
    input logic [7:0]             att_l,
    input logic [2:0]             fmt_sel,
    input logic [1:0]             deemph_sel
);

    // R5: only implemented registers are ever strobed
    assert_addr_in_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < ADDR_W'(NREG)));

    // R6: the register image moves only after a write strobe or power-down
    assert_image_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pdn_s) && !$past(wr_en)) |-> $stable(reg_flat));

    // R7: the edge count never passes the frame length
    assert_count_capped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_BITS));

    // R9: deselection clears the frame position
    assert_deselect_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n_s) |-> (bit_cnt == '0));

    // R8: power-down restores defaults
    assert_pdn_defaults_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pdn_s) |-> (att_l == 8'h00 && fmt_sel == 3'b010 && deemph_sel == 2'b01));

    // R8: no write strobe is issued out of power-down
    assert_pdn_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(pdn_s));

endmodule

bind ctl_serial_regport ctl_serial_regport_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pdn_s      (pdn_s),
    .cs_n_s     (cs_n_s),
    .bit_cnt    (bit_cnt),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .reg_flat   (reg_flat),
    .att_l      (att_l),
    .fmt_sel    (fmt_sel),
    .deemph_sel (deemph_sel)
);

// File: tb/ctl_serial_regport_test.sv
// Directed bench: one task per scenario, each checking its own results
// against a register model built from the requirements.
module ctl_serial_regport_test;

    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pdn_n = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdin = 1'b0;

    logic       vref_pwr, dac_pwr, hp_pwr_l, hp_pwr_r, hp_unmute;
    logic [1:0] osr_sel;
    logic [2:0] fmt_sel;
    logic       mono_mix, mclk_ac;
    logic [1:0] deemph_sel, boost_sel;
    logic       soft_mute, lr_inv, bclk_inv, att_link, att_slow;
    logic [7:0] att_l, att_r;
    logic       route_l, route_r;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [7];

    always #2.5 clk = ~clk;

    ctl_serial_regport uut (
        .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
        .vref_pwr(vref_pwr), .dac_pwr(dac_pwr), .hp_pwr_l(hp_pwr_l), .hp_pwr_r(hp_pwr_r),
        .hp_unmute(hp_unmute), .osr_sel(osr_sel), .fmt_sel(fmt_sel), .mono_mix(mono_mix),
        .mclk_ac(mclk_ac), .deemph_sel(deemph_sel), .boost_sel(boost_sel),
        .soft_mute(soft_mute), .lr_inv(lr_inv), .bclk_inv(bclk_inv), .att_link(att_link),
        .att_slow(att_slow), .att_l(att_l), .att_r(att_r), .route_l(route_l), .route_r(route_r)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic model_defaults();
        mdl[0] = 8'h00; mdl[1] = 8'h08; mdl[2] = 8'h01;
        mdl[3] = 8'h00; mdl[4] = 8'h00; mdl[5] = 8'h00; mdl[6] = 8'h00;
    endtask

    // Compare every field against the model, with positions from R10
    task automatic check_all(input string req);
        chk(req, "vref_pwr",   {7'd0, vref_pwr},   {7'd0, mdl[0][0]});
        chk(req, "dac_pwr",    {7'd0, dac_pwr},    {7'd0, mdl[0][1]});
        chk(req, "hp_pwr_l",   {7'd0, hp_pwr_l},   {7'd0, mdl[0][2]});
        chk(req, "hp_pwr_r",   {7'd0, hp_pwr_r},   {7'd0, mdl[0][3]});
        chk(req, "hp_unmute",  {7'd0, hp_unmute},  {7'd0, mdl[0][4]});
        chk(req, "osr_sel",    {6'd0, osr_sel},    {6'd0, mdl[1][1:0]});
        chk(req, "fmt_sel",    {5'd0, fmt_sel},    {5'd0, mdl[1][4:2]});
        chk(req, "mono_mix",   {7'd0, mono_mix},   {7'd0, mdl[1][5]});
        chk(req, "mclk_ac",    {7'd0, mclk_ac},    {7'd0, mdl[1][6]});
        chk(req, "deemph_sel", {6'd0, deemph_sel}, {6'd0, mdl[2][1:0]});
        chk(req, "boost_sel",  {6'd0, boost_sel},  {6'd0, mdl[2][3:2]});
        chk(req, "soft_mute",  {7'd0, soft_mute},  {7'd0, mdl[2][4]});
        chk(req, "lr_inv",     {7'd0, lr_inv},     {7'd0, mdl[3][0]});
        chk(req, "bclk_inv",   {7'd0, bclk_inv},   {7'd0, mdl[3][1]});
        chk(req, "att_link",   {7'd0, att_link},   {7'd0, mdl[3][2]});
        chk(req, "att_slow",   {7'd0, att_slow},   {7'd0, mdl[3][3]});
        chk(req, "att_l",      att_l,              mdl[4]);
        chk(req, "att_r",      att_r,              mdl[5]);
        chk(req, "route_l",    {7'd0, route_l},    {7'd0, mdl[6][0]});
        chk(req, "route_r",    {7'd0, route_r},    {7'd0, mdl[6][1]});
    endtask

    function automatic logic [15:0] mkframe(input logic [1:0] dev, input logic wr,
                                            input logic [4:0] addr, input logic [7:0] data);
        return {dev, wr, addr, data};
    endfunction

    task automatic sel_on();
        cs_n = 1'b0;
        wait_half();
    endtask

    task automatic sel_off();
        wait_half();
        cs_n = 1'b1;
        wait_half();
        wait_half();
    endtask

    task automatic clk_bit(input logic b, input logic drop_pdn);
        sdin = b;
        wait_half();
        if (drop_pdn) pdn_n = 1'b0;
        sclk = 1'b1;
        wait_half();
        sclk = 1'b0;
    endtask

    // Full selection with a chosen number of edges; edges past 16 send ones
    task automatic send(input logic [15:0] fr, input int edges);
        sel_on();
        for (int i = 0; i < edges; i++)
            clk_bit((i < 16) ? fr[15-i] : 1'b1, 1'b0);
        sel_off();
    endtask

    task automatic write_ok(input logic [4:0] addr, input logic [7:0] data);
        send(mkframe(2'b01, 1'b1, addr, data), 16);
        mdl[addr] = data;
    endtask

    task automatic t_reset();
        check_all("R1");
    endtask

    task automatic t_fields();
        write_ok(5'd0, 8'h1F);
        write_ok(5'd1, 8'h57);
        write_ok(5'd2, 8'h1E);
        write_ok(5'd3, 8'h0F);
        write_ok(5'd4, 8'hA5);
        write_ok(5'd5, 8'h3C);
        write_ok(5'd6, 8'h03);
        check_all("R2");
        write_ok(5'd0, 8'h0A);
        write_ok(5'd1, 8'h28);
        write_ok(5'd3, 8'h05);
        check_all("R10");
    endtask

    task automatic t_bad_dev();
        send(mkframe(2'b10, 1'b1, 5'd4, 8'hFF), 16);
        send(mkframe(2'b00, 1'b1, 5'd5, 8'hFF), 16);
        send(mkframe(2'b11, 1'b1, 5'd6, 8'h00), 16);
        check_all("R3");
    endtask

    task automatic t_bad_dir();
        send(mkframe(2'b01, 1'b0, 5'd4, 8'h11), 16);
        send(mkframe(2'b01, 1'b0, 5'd0, 8'h00), 16);
        check_all("R4");
    endtask

    task automatic t_bad_addr();
        send(mkframe(2'b01, 1'b1, 5'h07, 8'hFF), 16);
        send(mkframe(2'b01, 1'b1, 5'h1F, 8'hFF), 16);
        send(mkframe(2'b01, 1'b1, 5'h0C, 8'h00), 16);
        check_all("R5");
    endtask

    // Register must not change after 15 edges, and must after the 16th
    task automatic t_commit_edge();
        logic [15:0] fr;
        fr = mkframe(2'b01, 1'b1, 5'd5, 8'h96);
        sel_on();
        for (int i = 0; i < 15; i++) clk_bit(fr[15-i], 1'b0);
        wait_half();
        chk("R6", "att_r after 15 edges", att_r, mdl[5]);
        clk_bit(fr[0], 1'b0);
        wait_half();
        chk("R6", "att_r after 16 edges", att_r, 8'h96);
        sel_off();
        mdl[5] = 8'h96;
    endtask

    task automatic t_extra_edges();
        send(mkframe(2'b01, 1'b1, 5'd6, 8'h02), 21);
        mdl[6] = 8'h02;
        check_all("R7");
    endtask

    task automatic t_abort();
        send(mkframe(2'b01, 1'b1, 5'd4, 8'h77), 15);
        chk("R9", "att_l after aborted frame", att_l, mdl[4]);
        write_ok(5'd4, 8'h5A);
        check_all("R9");
    endtask

    task automatic t_pdn();
        logic [15:0] fr;
        pdn_n = 1'b0;
        wait_half();
        model_defaults();
        check_all("R8");
        send(mkframe(2'b01, 1'b1, 5'd4, 8'hC3), 16);
        chk("R8", "att_l write during power-down", att_l, 8'h00);
        pdn_n = 1'b1;
        wait_half();
        check_all("R8");
        // Power-down lands in the same cycle as the 16th edge
        write_ok(5'd5, 8'h44);
        fr = mkframe(2'b01, 1'b1, 5'd4, 8'hE1);
        sel_on();
        for (int i = 0; i < 16; i++) clk_bit(fr[15-i], i == 15);
        sel_off();
        model_defaults();
        check_all("R8");
        pdn_n = 1'b1;
        wait_half();
        chk("R8", "att_l after collided write", att_l, 8'h00);
        write_ok(5'd4, 8'h3E);
        check_all("R8");
    endtask

    initial begin
        model_defaults();
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        t_reset();
        t_fields();
        t_bad_dev();
        t_bad_dir();
        t_bad_addr();
        t_commit_edge();
        t_extra_edges();
        t_abort();
        t_pdn();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule